// File: doc/BRIEF.md
# Soft-Repair Shift Clock Sequencer

This block drives the serial transfer of repair codes from one shared repair-analysis unit into the fuse register of a chosen embedded memory. When the memory self-test engine finishes a test group it pulses a start input, along with the index of the memory to repair and a mode select. The sequencer then gates a free-running fuse clock so that one memory's fuse clock and the analyzer's shift clock pulse together. Each pulse moves one repair bit from the analyzer output into the memory fuse register input.

Each memory has its own fuse chain length, fixed when the design is elaborated. In plain mode the sequence gives exactly that many pulses. In incremental mode it gives twice the length plus one. During the first L of those pulses the repair code already held in the memory moves back into the analyzer. A one-cycle merge strobe then tells the analyzer to combine the old and new codes, and the remaining pulses load the merged result. Every clock gate holds its enable in a latch that is open only while the fuse clock is low, so the gated clocks cannot glitch.

Top module: `soft_repair_seq`

## Requirements
- R1: After reset, busy, done, idErr and mergeTrig are low and no gated clock pulses until a start is accepted.
- R2: In plain mode (incMode = 0), the memory selected by memId receives exactly CHAIN_LEN[memId] pulses on memClk[memId].
- R3: At most one bit of memClk is ever high, and every non-selected memory receives no pulses during a sequence.
- R4: anaClk pulses exactly when the selected memory clock pulses. In plain mode, after the sequence, the low L bits of that memory's fuse register hold the first L bits shifted out of the analyzer, MSB first.
- R5: In incremental mode (incMode = 1), the selected memory and the analyzer each receive 2·L+1 pulses.
- R6: In incremental mode, mergeTrig is high for exactly one fuse clock cycle, starting at the rising edge of the L-th pulse, and it is high only while busy. In plain mode it stays low.
- R7: A start accepted at clock edge t makes busy high from t through edge t+P (P being the pulse count). done is high for the single cycle that follows, and busy falls only together with done rising.
- R8: A start that arrives while busy is ignored. memId and incMode are captured when the start is accepted, so changing them during a sequence has no effect.
- R9: A memId of NMEM or above gives no pulses and no busy. done and idErr are both high for the one cycle after the start edge, and idErr is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fuseClk | input | 1 | Free-running fuse shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Start request from the memory self-test engine |
| memId | input | IDW | Index of the memory to repair |
| incMode | input | 1 | 1 selects incremental (merge) transfer |
| memClk | output | NMEM | Gated fuse clocks, one per memory |
| anaClk | output | 1 | Gated shift clock of the repair analyzer |
| mergeTrig | output | 1 | One-cycle strobe that tells the analyzer to merge old and new codes |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| idErr | output | 1 | The requested memory index was out of range (pulses with done) |

## Verification
A wrong pulse counter or a wrong length lookup appears at the ports as a pulse count on the selected memory clock that is off by one or more. It also moves the done pulse away from t+P, so the fault shows as soon as the first sequence for that memory ends. A corrupt selection register shows as pulses on the wrong memory clock, or as two memory clocks high in the same phase, within the first pulse. A misplaced merge comparison moves mergeTrig away from pulse L in the first incremental run for that memory, and a captured-state fault shows when the inputs are disturbed during a running sequence.

// File: rtl/srseq_pkg.sv
package srseq_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;   // capture memId and incMode, clear the pulse counter
    logic run;    // sequence active: step the counter and open the selected gates
  } seqStrobe_t;

  // Conditions reported by the datapath to the control
  typedef struct packed {
    logic idBad;    // requested index is out of range
    logic atMerge;  // counter at the merge point (incremental mode only)
    logic atLast;   // counter at the final pulse
  } seqFlags_t;
endpackage

// File: rtl/srseq_clk_gate.sv
module srseq_clk_gate (
  input  logic clkIn,
  input  logic en,
  output logic gclk
);
  logic enLat;

  // The enable can only change while the clock is low, so the output cannot glitch
  always_latch begin
    if (!clkIn) enLat = en;
  end

  assign gclk = clkIn & enLat;
endmodule

// File: rtl/srseq_ctrl.sv
module srseq_ctrl
  import srseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigger,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       idErr,
  output logic       mergeTrig
);
  logic accept;
  logic reject;

  assign accept = !busy && trigger && !flags.idBad;
  assign reject = !busy && trigger && flags.idBad;

  assign strobe.load = accept;
  assign strobe.run  = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      idErr     <= 1'b0;
      mergeTrig <= 1'b0;
    end else begin
      done      <= (busy && flags.atLast) || reject;
      idErr     <= reject;
      mergeTrig <= busy && flags.atMerge;
      if (accept)                     busy <= 1'b1;
      else if (busy && flags.atLast)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/srseq_datapath.sv
module srseq_datapath
  import srseq_pkg::*;
#(
  parameter int NMEM = 4,
  parameter int IDW  = 3,
  parameter int LENW = 16,
  parameter logic [LENW-1:0] CHAIN_LEN [NMEM] = '{16'd4, 16'd2, 16'd9, 16'd5}
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IDW-1:0]  memId,
  input  logic            incMode,
  input  seqStrobe_t      strobe,
  output seqFlags_t       flags,
  output logic [NMEM-1:0] memClk,
  output logic            anaClk
);
  localparam int CW = LENW + 1;   // wide enough for 2*L

  logic [IDW-1:0]  selId;
  logic            incSel;
  logic [CW-1:0]   cnt;
  logic [LENW-1:0] lenSel;
  logic [CW-1:0]   lenExt;
  logic [CW-1:0]   lastIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selId  <= '0;
      incSel <= 1'b0;
      cnt    <= '0;
    end else if (strobe.load) begin
      selId  <= memId;
      incSel <= incMode;
      cnt    <= '0;
    end else if (strobe.run) begin
      cnt    <= cnt + 1'b1;
    end
  end

  // Chain length of the captured memory
  always_comb begin
    lenSel = '0;
    for (int i = 0; i < NMEM; i++)
      if (selId == IDW'(i)) lenSel = CHAIN_LEN[i];
  end

  assign lenExt  = {1'b0, lenSel};
  assign lastIdx = incSel ? {lenSel, 1'b0} : lenExt - 1'b1;

  assign flags.idBad   = {1'b0, memId} >= (IDW+1)'(NMEM);
  assign flags.atMerge = incSel && (cnt == lenExt - 1'b1);
  assign flags.atLast  = (cnt == lastIdx);

  generate
    for (genvar g = 0; g < NMEM; g++) begin : gMemGate
      srseq_clk_gate u_gate (
        .clkIn (clk),
        .en    (strobe.run && (selId == IDW'(g))),
        .gclk  (memClk[g])
      );
    end
  endgenerate

  srseq_clk_gate u_anaGate (
    .clkIn (clk),
    .en    (strobe.run),
    .gclk  (anaClk)
  );
endmodule

// File: rtl/soft_repair_seq.sv
module soft_repair_seq
  import srseq_pkg::*;
#(
  parameter int NMEM = 4,
  parameter int IDW  = 3,
  parameter int LENW = 16,
  parameter logic [LENW-1:0] CHAIN_LEN [NMEM] = '{16'd4, 16'd2, 16'd9, 16'd5}
) (
  input  logic            fuseClk,
  input  logic            rstN,
  input  logic            trigger,
  input  logic [IDW-1:0]  memId,
  input  logic            incMode,
  output logic [NMEM-1:0] memClk,
  output logic            anaClk,
  output logic            mergeTrig,
  output logic            busy,
  output logic            done,
  output logic            idErr
);
  seqStrobe_t strobe;
  seqFlags_t  flags;

  srseq_ctrl u_ctrl (
    .clk       (fuseClk),
    .rstN      (rstN),
    .trigger   (trigger),
    .flags     (flags),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .idErr     (idErr),
    .mergeTrig (mergeTrig)
  );

  srseq_datapath #(
    .NMEM      (NMEM),
    .IDW       (IDW),
    .LENW      (LENW),
    .CHAIN_LEN (CHAIN_LEN)
  ) u_dp (
    .clk     (fuseClk),
    .rstN    (rstN),
    .memId   (memId),
    .incMode (incMode),
    .strobe  (strobe),
    .flags   (flags),
    .memClk  (memClk),
    .anaClk  (anaClk)
  );
endmodule

// File: rtl/soft_repair_seq_chk.sv
module soft_repair_seq_chk #(
  parameter int NMEM = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic            idErr,
  input logic            mergeTrig,
  input logic [NMEM-1:0] memClk,
  input logic            anaClk
);
  // R3
  one_mem_clk_chk: assert property (@(negedge clk) disable iff (!rstN)
    $onehot0(memClk));

  // R4
  ana_follows_mem_chk: assert property (@(negedge clk) disable iff (!rstN)
    (|memClk) |-> anaClk);

  // R6
  merge_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    mergeTrig |-> busy);

  // R6
  merge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    mergeTrig |=> !mergeTrig);

  // R7
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    idErr |-> done);
endmodule

bind soft_repair_seq soft_repair_seq_chk #(.NMEM(NMEM)) u_chk (
  .clk       (fuseClk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .idErr     (idErr),
  .mergeTrig (mergeTrig),
  .memClk    (memClk),
  .anaClk    (anaClk)
);

// File: tb/soft_repair_seq_tb.sv
`timescale 1ns/1ps
module soft_repair_seq_tb;
  localparam int NMEM = 4;
  localparam int IDW  = 3;
  localparam int LENW = 16;
  localparam logic [LENW-1:0] LENS [NMEM] = '{16'd3, 16'd1, 16'd7, 16'd12};
  localparam logic [31:0] PAT = 32'hA5C3_96E1;

  logic            fuseClk = 1'b0;
  logic            rstN = 1'b0;
  logic            trigger = 1'b0;
  logic [IDW-1:0]  memId = '0;
  logic            incMode = 1'b0;
  logic [NMEM-1:0] memClk;
  logic            anaClk, mergeTrig, busy, done, idErr;

  int nTests = 0;
  int nFail  = 0;

  soft_repair_seq #(.NMEM(NMEM), .IDW(IDW), .LENW(LENW), .CHAIN_LEN(LENS)) u_dut (
    .fuseClk(fuseClk), .rstN(rstN), .trigger(trigger), .memId(memId),
    .incMode(incMode), .memClk(memClk), .anaClk(anaClk),
    .mergeTrig(mergeTrig), .busy(busy), .done(done), .idErr(idErr)
  );

  always #10 fuseClk = ~fuseClk;   // 50 MHz

  // Observers, sampled 1 ns into the high phase; analyzer and fuse registers modelled as shift registers
  int          cyc = 0;
  int          memCnt [NMEM];
  int          anaCnt = 0, mergeCnt = 0, mergeAt = -1;
  int          busyCnt = 0, doneCnt = 0, errCnt = 0, doneCyc = -1;
  logic [31:0] anaSr = PAT;
  logic [31:0] fuseSr [NMEM];

  initial for (int i = 0; i < NMEM; i++) begin memCnt[i] = 0; fuseSr[i] = '0; end

  always @(posedge fuseClk) begin
    #1;
    cyc++;
    if (rstN) begin
      for (int i = 0; i < NMEM; i++)
        if (memClk[i]) begin
          memCnt[i]++;
          fuseSr[i] = {fuseSr[i][30:0], anaSr[31]};
        end
      if (anaClk) begin
        anaCnt++;
        anaSr = {anaSr[30:0], anaSr[31]};
      end
      if (mergeTrig) begin mergeCnt++; mergeAt = anaCnt; end
      if (busy) busyCnt++;
      if (done) begin doneCnt++; doneCyc = cyc; end
      if (idErr) errCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one sequence; disturb = 1 changes inputs and re-triggers mid-sequence
  task automatic runSeq(input int id, input bit inc, input bit disturb);
    int m0 [NMEM];
    int a0, g0, b0, d0, e0, tc, len, p, waitN;
    logic [31:0] s0;
    bit bad;
    for (int i = 0; i < NMEM; i++) m0[i] = memCnt[i];
    a0 = anaCnt; g0 = mergeCnt; b0 = busyCnt; d0 = doneCnt; e0 = errCnt;
    s0 = anaSr;
    bad = (id >= NMEM);
    len = bad ? 0 : int'(LENS[id]);
    p = bad ? 0 : (inc ? 2 * len + 1 : len);
    mergeAt = -1;
    @(negedge fuseClk);
    memId = IDW'(id); incMode = inc; trigger = 1'b1;
    tc = cyc + 1;
    @(negedge fuseClk);
    trigger = 1'b0;
    if (disturb) begin
      @(negedge fuseClk);
      memId = 3'd0; incMode = ~inc; trigger = 1'b1;
      @(negedge fuseClk);
      trigger = 1'b0;
    end
    waitN = 0;
    while (doneCnt == d0 && waitN < 200) begin @(negedge fuseClk); waitN++; end
    repeat (3) @(negedge fuseClk);

    chk(doneCnt - d0 == 1, "R7", $sformatf("done pulses id%0d inc%0d", id, inc), doneCnt - d0, 1);
    if (bad) begin
      chk(errCnt - e0 == 1, "R9", $sformatf("idErr pulses id%0d", id), errCnt - e0, 1);
      chk(doneCyc == tc, "R9", "done cycle after bad id", doneCyc - tc, 0);
      chk(busyCnt == b0, "R9", "busy cycles for bad id", busyCnt - b0, 0);
      chk(anaCnt == a0, "R9", "analyzer pulses for bad id", anaCnt - a0, 0);
      for (int i = 0; i < NMEM; i++)
        chk(memCnt[i] == m0[i], "R9", $sformatf("mem%0d pulses for bad id", i), memCnt[i] - m0[i], 0);
    end else begin
      chk(errCnt == e0, "R9", "idErr on valid id", errCnt - e0, 0);
      for (int i = 0; i < NMEM; i++) begin
        if (i == id)
          chk(memCnt[i] - m0[i] == p, inc ? "R5" : "R2",
              $sformatf("mem%0d pulses inc%0d", i, inc), memCnt[i] - m0[i], p);
        else
          chk(memCnt[i] == m0[i], "R3", $sformatf("mem%0d stray pulses (sel %0d)", i, id),
              memCnt[i] - m0[i], 0);
      end
      chk(anaCnt - a0 == p, "R4", $sformatf("analyzer pulses id%0d inc%0d", id, inc), anaCnt - a0, p);
      chk(busyCnt - b0 == p, "R7", $sformatf("busy cycles id%0d inc%0d", id, inc), busyCnt - b0, p);
      chk(doneCyc == tc + p, "R7", "done cycle offset", doneCyc - tc, p);
      if (inc) begin
        chk(mergeCnt - g0 == 1, "R6", $sformatf("merge pulses id%0d", id), mergeCnt - g0, 1);
        chk(mergeAt - a0 == len, "R6", $sformatf("merge position id%0d", id), mergeAt - a0, len);
      end else begin
        logic [31:0] mask, expv;
        mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
        expv = s0 >> (32 - len);
        chk(mergeCnt == g0, "R6", "merge in plain mode", mergeCnt - g0, 0);
        chk((fuseSr[id] & mask) == expv, "R4", $sformatf("fuse data mem%0d", id),
            int'(fuseSr[id] & mask), int'(expv));
      end
      if (disturb)
        chk(1'b1 && (memCnt[0] == m0[0]), "R8", "re-trigger leaked to mem0", memCnt[0] - m0[0], 0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge fuseClk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge fuseClk);
    // R1: reset state, with a trigger asserted while in reset
    trigger = 1'b1;
    @(negedge fuseClk);
    chk(!busy && !done && !idErr && !mergeTrig, "R1", "status in reset",
        int'({busy, done, idErr, mergeTrig}), 0);
    chk(memClk == '0 && !anaClk, "R1", "clocks in reset", int'(memClk), 0);
    trigger = 1'b0;
    rstN = 1'b1;
    repeat (4) @(negedge fuseClk);
    chk(!busy && !done && !idErr && !mergeTrig, "R1", "status after reset",
        int'({busy, done, idErr, mergeTrig}), 0);
    chk(memCnt[0] + memCnt[1] + memCnt[2] + memCnt[3] + anaCnt == 0, "R1", "pulses after reset",
        memCnt[0] + memCnt[1] + memCnt[2] + memCnt[3] + anaCnt, 0);

    // Sweep every id (including out-of-range) in both modes
    for (int id = 0; id < (1 << IDW); id++)
      for (int inc = 0; inc < 2; inc++)
        runSeq(id, inc[0], 1'b0);

    // R8: inputs changed and trigger re-asserted while busy
    runSeq(2, 1'b0, 1'b1);
    runSeq(3, 1'b1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule